// File: doc/BRIEF.md
# Gap-Coded Downlink Frame Decoder

This block turns a gap-modulated base-station command stream into decoded command fields. It runs on a system clock with a field-clock enable, and it watches a level input that is high while the analog front end reports the carrier as interrupted. A long interruption seen while idle opens a frame. After that, each bit is carried by how long the carrier stays on between two interruptions. A short on-time is a zero and a long on-time is a one.

Each accepted bit is shifted into a frame register. The first two bits form the opcode. The frame ends when the carrier stays on past the longest legal one-interval. At that point the number of received bits is checked against the length that the opcode allows. The block then produces one of three results for one clock: a decoded command (write, direct read or reset), a bit error, or a frame error. The surrounding controller uses these results to start programming or to restart the reply stream. Gap detection itself and memory programming are outside this block.

Top module: `gap_frame_decoder`

## Requirements
- R1: After reset `dl_active` is 0 and none of `res_valid`, `bit_err` or `frame_err` is set.
- R2: A high phase of `gap_i` lasting at least START_MIN (40) field ticks opens a frame when it ends, but only while idle and with `init_done` = 1. `dl_active` then reads 1. A shorter high phase, or any high phase seen with `init_done` = 0, leaves the block idle.
- R3: Inside a frame, a low phase of 16 to 32 field ticks (both ends included) that ends in a gap gives a 0. A low phase of 48 to 64 ticks gives a 1. Bits arrive most significant first, so the first data bit received lands in `res_data[31]`.
- R4: A low phase that ends in a gap with a length outside both windows (for example 10 or 40 ticks) ends the frame with a one-cycle `bit_err`. No command is reported.
- R5: The frame stays open while every low phase is 64 ticks or shorter. A low phase longer than 64 ticks closes the frame, and the bit count is judged at that moment.
- R6: Opcode 11 with 40 bits is a write (`res_kind` = 0). The lock bit comes third, then 32 data bits, then a 5-bit address, and `res_op` = 11.
- R7: Opcode 11 with 7 bits is a direct read (`res_kind` = 1) of the 5-bit address that follows the opcode.
- R8: Opcode 10 with 38 bits is a write (`res_kind` = 0) made of a lock bit, 32 data bits and a 3-bit address. The address is zero-extended into `res_addr`.
- R9: Opcode 00 with exactly 2 bits is a reset command (`res_kind` = 2).
- R10: A frame with opcode 01 of any length produces no result pulse, and the block returns to idle (`dl_active` = 0).
- R11: A closed frame whose bit count does not fit its opcode gives a one-cycle `frame_err` and no command. A frame with fewer than 2 bits also counts as a wrong length.
- R12: At most one of `res_valid`, `bit_err` and `frame_err` is set in any cycle. Each one lasts a single cycle and coincides with `dl_active` falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_en | input | 1 | One-cycle enable per field clock period |
| gap_i | input | 1 | High while a carrier gap is detected |
| init_done | input | 1 | Start-up configuration finished |
| dl_active | output | 1 | A downlink frame is being received |
| res_valid | output | 1 | Decoded command strobe |
| res_kind | output | 2 | 0 write, 1 direct read, 2 reset |
| res_op | output | 2 | Received opcode |
| res_lock | output | 1 | Lock bit of a write |
| res_data | output | 32 | Data word of a write |
| res_addr | output | 5 | Block address |
| bit_err | output | 1 | Interval outside both bit windows |
| frame_err | output | 1 | Bit count wrong for the opcode |

## Verification
Every legal command shape is sent with typical intervals of 24 and 56 ticks: long write, short write, direct read and reset. Matching fields confirm how the frame register is sliced for each length. A read frame built only from the window edges (16, 32, 48, 64) separates inclusive bounds from off-by-one bounds. Intervals of 10 and 40 ticks probe the space below and between the windows. Frames with a wrong bit count for opcode 11 or 10, an opcode-01 frame that must stay silent, a start gap that is too short, and a start gap sent before initialization separate the error, ignore and reject paths from a real decode. A 64-tick tail that still keeps `dl_active` high pins down exactly where the frame closes.

// File: rtl/gap_frame_pkg.sv
package gap_frame_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RX   = 1'b1
  } dl_state_e;

  typedef enum logic [1:0] {
    K_WRITE = 2'd0,
    K_READ  = 2'd1,
    K_RESET = 2'd2,
    K_NONE  = 2'd3
  } frame_kind_e;

  typedef enum logic [1:0] {
    V_OK  = 2'd0,
    V_IGN = 2'd1,
    V_ERR = 2'd2
  } verdict_e;

endpackage

// File: rtl/gap_frame_timer.sv
module gap_frame_timer #(
  parameter int START_MIN = 40,
  parameter int ONE_MAX   = 64,
  localparam int LW = $clog2(START_MIN + 1),
  localparam int IW = $clog2(ONE_MAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fc_en,
  input  logic          gap_i,
  output logic          gap_rise,
  output logic          gap_fall,
  output logic          long_gap,
  output logic [IW-1:0] ivl_cnt,
  output logic          ivl_over
);

  localparam logic [LW-1:0] LEN_SAT = LW'(START_MIN);
  localparam logic [IW-1:0] IVL_SAT = IW'(ONE_MAX + 1);

  logic          gap_q, gap_nx;
  logic [LW-1:0] len_q, len_nx;
  logic [IW-1:0] ivl_q, ivl_nx;

  always_comb begin
    gap_nx = gap_q;
    len_nx = len_q;
    ivl_nx = ivl_q;
    if (fc_en) begin
      gap_nx = gap_i;
      if (gap_i) begin
        if (!gap_q)                len_nx = LW'(1);
        else if (len_q != LEN_SAT) len_nx = len_q + LW'(1);
      end else begin
        if (gap_q)                 ivl_nx = IW'(1);
        else if (ivl_q != IVL_SAT) ivl_nx = ivl_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 1'b0;
      len_q <= '0;
      ivl_q <= '0;
    end else begin
      gap_q <= gap_nx;
      len_q <= len_nx;
      ivl_q <= ivl_nx;
    end
  end

  assign gap_rise = fc_en &  gap_i & ~gap_q;
  assign gap_fall = fc_en & ~gap_i &  gap_q;
  assign long_gap = (len_q == LEN_SAT);
  assign ivl_cnt  = ivl_q;
  assign ivl_over = (ivl_q == IVL_SAT);

endmodule

// File: rtl/gap_frame_shift.sv
module gap_frame_shift #(
  parameter int SR_W = 40,
  localparam int CW = $clog2(SR_W + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift,
  input  logic            bit_in,
  output logic [SR_W-1:0] sr,
  output logic [CW-1:0]   cnt,
  output logic [1:0]      op
);

  localparam logic [CW-1:0] CNT_SAT = CW'(SR_W + 1);

  logic [SR_W-1:0] sr_q, sr_nx;
  logic [CW-1:0]   cnt_q, cnt_nx;
  logic [1:0]      op_q, op_nx;

  always_comb begin
    sr_nx  = sr_q;
    cnt_nx = cnt_q;
    op_nx  = op_q;
    if (clr) begin
      sr_nx  = '0;
      cnt_nx = '0;
      op_nx  = 2'b00;
    end else if (shift) begin
      sr_nx = {sr_q[SR_W-2:0], bit_in};
      if (cnt_q != CNT_SAT) cnt_nx = cnt_q + CW'(1);
      if (cnt_q == CW'(1))  op_nx  = {sr_q[0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      op_q  <= 2'b00;
    end else begin
      sr_q  <= sr_nx;
      cnt_q <= cnt_nx;
      op_q  <= op_nx;
    end
  end

  assign sr  = sr_q;
  assign cnt = cnt_q;
  assign op  = op_q;

endmodule

// File: rtl/gap_frame_check.sv
module gap_frame_check
  import gap_frame_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_LONG  = 5,
  parameter int ADDR_SHORT = 3,
  parameter int CW         = 6,
  localparam int LEN_LONG  = 3 + DATA_W + ADDR_LONG,
  localparam int LEN_SHORT = 3 + DATA_W + ADDR_SHORT,
  localparam int LEN_READ  = 2 + ADDR_LONG,
  localparam int BODY_W    = LEN_LONG - 2
) (
  input  logic [BODY_W-1:0]    body,
  input  logic [CW-1:0]        cnt,
  input  logic [1:0]           op,
  output verdict_e             verdict,
  output frame_kind_e          kind,
  output logic                 lock,
  output logic [DATA_W-1:0]    data,
  output logic [ADDR_LONG-1:0] addr
);

  localparam logic [CW-1:0] N_LONG  = CW'(LEN_LONG);
  localparam logic [CW-1:0] N_SHORT = CW'(LEN_SHORT);
  localparam logic [CW-1:0] N_READ  = CW'(LEN_READ);
  localparam logic [CW-1:0] N_OP    = CW'(2);

  always_comb begin
    verdict = V_ERR;
    kind    = K_NONE;
    lock    = 1'b0;
    data    = '0;
    addr    = '0;
    if (cnt >= N_OP) begin
      unique case (op)
        2'b11: begin
          if (cnt == N_LONG) begin
            verdict = V_OK;
            kind    = K_WRITE;
            lock    = body[LEN_LONG-3];
            data    = body[ADDR_LONG +: DATA_W];
            addr    = body[ADDR_LONG-1:0];
          end else if (cnt == N_READ) begin
            verdict = V_OK;
            kind    = K_READ;
            addr    = body[ADDR_LONG-1:0];
          end
        end
        2'b10: begin
          if (cnt == N_SHORT) begin
            verdict = V_OK;
            kind    = K_WRITE;
            lock    = body[LEN_SHORT-3];
            data    = body[ADDR_SHORT +: DATA_W];
            addr    = {{(ADDR_LONG-ADDR_SHORT){1'b0}}, body[ADDR_SHORT-1:0]};
          end
        end
        2'b00: begin
          if (cnt == N_OP) begin
            verdict = V_OK;
            kind    = K_RESET;
          end
        end
        default: verdict = V_IGN;
      endcase
    end
  end

endmodule

// File: rtl/gap_frame_decoder.sv
module gap_frame_decoder
  import gap_frame_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_LONG  = 5,
  parameter int ADDR_SHORT = 3,
  parameter int ZERO_MIN   = 16,
  parameter int ZERO_MAX   = 32,
  parameter int ONE_MIN    = 48,
  parameter int ONE_MAX    = 64,
  parameter int START_MIN  = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fc_en,
  input  logic                 gap_i,
  input  logic                 init_done,
  output logic                 dl_active,
  output logic                 res_valid,
  output logic [1:0]           res_kind,
  output logic [1:0]           res_op,
  output logic                 res_lock,
  output logic [DATA_W-1:0]    res_data,
  output logic [ADDR_LONG-1:0] res_addr,
  output logic                 bit_err,
  output logic                 frame_err
);

  localparam int SR_W = 3 + DATA_W + ADDR_LONG;
  localparam int CW   = $clog2(SR_W + 2);
  localparam int IW   = $clog2(ONE_MAX + 2);
  localparam logic [IW-1:0] Z_LO = IW'(ZERO_MIN);
  localparam logic [IW-1:0] Z_HI = IW'(ZERO_MAX);
  localparam logic [IW-1:0] O_LO = IW'(ONE_MIN);
  localparam logic [IW-1:0] O_HI = IW'(ONE_MAX);

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic          gap_rise, gap_fall, long_gap, ivl_over;
  logic [IW-1:0] ivl_cnt;

  gap_frame_timer #(.START_MIN(START_MIN), .ONE_MAX(ONE_MAX)) u_timer (
    .clk(clk), .rst_n(rst_s2), .fc_en(fc_en), .gap_i(gap_i),
    .gap_rise(gap_rise), .gap_fall(gap_fall), .long_gap(long_gap),
    .ivl_cnt(ivl_cnt), .ivl_over(ivl_over)
  );

  logic            sh_clr, sh_en, sh_bit;
  logic [SR_W-1:0] sr;
  logic [CW-1:0]   bcnt;
  logic [1:0]      op;

  gap_frame_shift #(.SR_W(SR_W)) u_shift (
    .clk(clk), .rst_n(rst_s2), .clr(sh_clr), .shift(sh_en), .bit_in(sh_bit),
    .sr(sr), .cnt(bcnt), .op(op)
  );

  verdict_e              verdict;
  frame_kind_e           fk;
  logic                  f_lock;
  logic [DATA_W-1:0]     f_data;
  logic [ADDR_LONG-1:0]  f_addr;

  gap_frame_check #(
    .DATA_W(DATA_W), .ADDR_LONG(ADDR_LONG), .ADDR_SHORT(ADDR_SHORT), .CW(CW)
  ) u_check (
    .body(sr[SR_W-3:0]), .cnt(bcnt), .op(op),
    .verdict(verdict), .kind(fk), .lock(f_lock), .data(f_data), .addr(f_addr)
  );

  dl_state_e st_q, st_nx;
  logic      vld_q, vld_nx, berr_q, berr_nx, ferr_q, ferr_nx;
  logic      is0, is1;

  assign is0 = (ivl_cnt >= Z_LO) && (ivl_cnt <= Z_HI);
  assign is1 = (ivl_cnt >= O_LO) && (ivl_cnt <= O_HI);

  always_comb begin
    st_nx   = st_q;
    sh_clr  = 1'b0;
    sh_en   = 1'b0;
    sh_bit  = is1;
    vld_nx  = 1'b0;
    berr_nx = 1'b0;
    ferr_nx = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (gap_fall && long_gap && init_done) begin
          st_nx  = ST_RX;
          sh_clr = 1'b1;
        end
      end
      ST_RX: begin
        if (fc_en) begin
          if (ivl_over) begin
            st_nx = ST_IDLE;
            if (verdict == V_OK)  vld_nx  = 1'b1;
            if (verdict == V_ERR) ferr_nx = 1'b1;
          end else if (gap_rise) begin
            if (is0 || is1) begin
              sh_en = 1'b1;
            end else begin
              berr_nx = 1'b1;
              st_nx   = ST_IDLE;
            end
          end
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      st_q   <= ST_IDLE;
      vld_q  <= 1'b0;
      berr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      vld_q  <= vld_nx;
      berr_q <= berr_nx;
      ferr_q <= ferr_nx;
    end
  end

  logic [1:0]           kind_q, op_q;
  logic                 lock_q;
  logic [DATA_W-1:0]    data_q;
  logic [ADDR_LONG-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      kind_q <= K_NONE;
      op_q   <= 2'b00;
      lock_q <= 1'b0;
      data_q <= '0;
      addr_q <= '0;
    end else if (vld_nx) begin
      kind_q <= fk;
      op_q   <= op;
      lock_q <= f_lock;
      data_q <= f_data;
      addr_q <= f_addr;
    end
  end

  assign dl_active = (st_q == ST_RX);
  assign res_valid = vld_q;
  assign bit_err   = berr_q;
  assign frame_err = ferr_q;
  assign res_kind  = kind_q;
  assign res_op    = op_q;
  assign res_lock  = lock_q;
  assign res_data  = data_q;
  assign res_addr  = addr_q;

endmodule

// File: rtl/gap_frame_checks.sv
module gap_frame_checks #(
  parameter int ADDR_LONG  = 5,
  parameter int ADDR_SHORT = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gap_i,
  input logic                 init_done,
  input logic                 dl_active,
  input logic                 res_valid,
  input logic [1:0]           res_kind,
  input logic [1:0]           res_op,
  input logic [ADDR_LONG-1:0] res_addr,
  input logic                 bit_err,
  input logic                 frame_err
);

  // R12: result pulses are exclusive
  p_one_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_valid, bit_err, frame_err}));

  // R12: every result closes the frame
  p_result_closes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || bit_err || frame_err) |-> ($fell(dl_active)));

  // R12: single-cycle strobe
  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R2: frames open only after initialization
  p_open_after_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dl_active) |-> $past(init_done));

  // R4: a bit error is raised on a gap edge
  p_biterr_on_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(gap_i));

  // R8: short-address writes zero-extend
  p_short_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_op == 2'b10) |-> (res_addr[ADDR_LONG-1:ADDR_SHORT] == '0));

  // R9: reset kind only from opcode 00
  p_reset_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'd2) |-> (res_op == 2'b00));

  // R10: opcode 01 never yields a command
  p_no_op01_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_op != 2'b01));

endmodule

bind gap_frame_decoder gap_frame_checks #(
  .ADDR_LONG(ADDR_LONG), .ADDR_SHORT(ADDR_SHORT)
) u_checks (
  .clk(clk), .rst_n(rst_n), .gap_i(gap_i), .init_done(init_done),
  .dl_active(dl_active), .res_valid(res_valid), .res_kind(res_kind),
  .res_op(res_op), .res_addr(res_addr), .bit_err(bit_err), .frame_err(frame_err)
);

// File: tb/gap_frame_decoder_bench.sv
module gap_frame_decoder_bench;

  logic        clk;
  logic        rst_n;
  logic        fc_en;
  logic        gap_i;
  logic        init_done;
  logic        dl_active, res_valid, res_lock, bit_err, frame_err;
  logic [1:0]  res_kind, res_op;
  logic [31:0] res_data;
  logic [4:0]  res_addr;

  gap_frame_decoder u_gap_frame_decoder (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .gap_i(gap_i), .init_done(init_done),
    .dl_active(dl_active), .res_valid(res_valid), .res_kind(res_kind),
    .res_op(res_op), .res_lock(res_lock), .res_data(res_data),
    .res_addr(res_addr), .bit_err(bit_err), .frame_err(frame_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // field clock enable every second system clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fc_en <= 1'b0;
    else        fc_en <= ~fc_en;
  end

  typedef struct {
    int          cls;   // 0 command, 1 bit error, 2 frame error
    logic [1:0]  kind;
    logic [1:0]  op;
    logic        lock;
    logic [31:0] data;
    logic [4:0]  addr;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int cls, input logic [1:0] kind, input logic [1:0] op,
                      input logic lock, input logic [31:0] data, input logic [4:0] addr,
                      input string req);
    exp_t e;
    e.cls = cls; e.kind = kind; e.op = op; e.lock = lock;
    e.data = data; e.addr = addr; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compare every produced result against the queue head
  always @(negedge clk) begin
    if (rst_n && (res_valid || bit_err || frame_err)) begin
      automatic int cls = res_valid ? 0 : (bit_err ? 1 : 2);
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R10/R12 unexpected result class actual=%0d expected=none", cls);
      end else begin
        automatic exp_t e = q.pop_front();
        automatic bit ok = (cls == e.cls);
        if (ok && cls == 0) begin
          ok = (res_kind == e.kind) && (res_op == e.op) && (res_addr == e.addr);
          if (e.kind == 2'd0) ok = ok && (res_lock == e.lock) && (res_data == e.data);
        end
        if (!ok) begin
          fails++;
          $display("FAIL %s actual cls=%0d kind=%0d op=%0d lock=%0d data=%h addr=%0d expected cls=%0d kind=%0d op=%0d lock=%0d data=%h addr=%0d",
                   e.req, cls, res_kind, res_op, res_lock, res_data, res_addr,
                   e.cls, e.kind, e.op, e.lock, e.data, e.addr);
        end
      end
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(posedge clk iff fc_en);
    #1;
  endtask

  task automatic lowfor(input int n);
    gap_i = 1'b0;
    ticks(n);
  endtask

  task automatic highfor(input int n);
    gap_i = 1'b1;
    ticks(n);
  endtask

  function automatic int blen(input logic b, input int style);
    if (style == 1) return b ? 48 : 16;
    if (style == 2) return b ? 64 : 32;
    return b ? 56 : 24;
  endfunction

  // driver: start gap, bits MSB first, then a closing tail
  task automatic send(input logic [39:0] bits, input int n, input int style, input int tail);
    highfor(50);
    for (int i = n - 1; i >= 0; i--) begin
      lowfor(blen(bits[i], style));
      highfor(10);
    end
    lowfor(tail);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; gap_i = 1'b0; init_done = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1
    chk(dl_active == 1'b0, "R1", "dl_active", dl_active, 0);
    chk({res_valid, bit_err, frame_err} == 3'b000, "R1", "pulses", {res_valid, bit_err, frame_err}, 0);

    // R6 + R3: long write
    push(0, 2'd0, 2'b11, 1'b1, 32'hA5C3_0F96, 5'd13, "R6");
    send({2'b11, 1'b1, 32'hA5C3_0F96, 5'd13}, 40, 0, 80);

    // R7: direct read
    push(0, 2'd1, 2'b11, 1'b0, 32'h0, 5'd22, "R7");
    send({33'h0, 2'b11, 5'd22}, 7, 0, 80);

    // R8: short-address write
    push(0, 2'd0, 2'b10, 1'b0, 32'h1234_5678, 5'd5, "R8");
    send({2'b00, 2'b10, 1'b0, 32'h1234_5678, 3'd5}, 38, 0, 80);

    // R3: window edges, low bounds then high bounds
    push(0, 2'd1, 2'b11, 1'b0, 32'h0, 5'b10110, "R3 low edges");
    send({33'h0, 2'b11, 5'b10110}, 7, 1, 80);
    push(0, 2'd1, 2'b11, 1'b0, 32'h0, 5'b01001, "R3 high edges");
    send({33'h0, 2'b11, 5'b01001}, 7, 2, 80);

    // R2 + R9 + R5: reset command, built by hand to probe dl_active
    push(0, 2'd2, 2'b00, 1'b0, 32'h0, 5'd0, "R9");
    highfor(50);
    lowfor(3);
    chk(dl_active == 1'b1, "R2", "dl_active after start gap", dl_active, 1);
    lowfor(21); highfor(10);
    lowfor(24); highfor(10);
    lowfor(64);
    chk(dl_active == 1'b1, "R5", "dl_active after 64-tick tail", dl_active, 1);
    lowfor(20);
    chk(dl_active == 1'b0, "R5", "dl_active after long tail", dl_active, 0);

    // R10: opcode 01 ignored
    send({33'h0, 2'b01, 5'd3}, 7, 0, 80);
    chk(dl_active == 1'b0, "R10", "dl_active after op01", dl_active, 0);

    // R11: wrong lengths
    push(2, 2'd0, 2'b00, 1'b0, 32'h0, 5'd0, "R11 op11 8 bits");
    send({32'h0, 2'b11, 6'd9}, 8, 0, 80);
    push(2, 2'd0, 2'b00, 1'b0, 32'h0, 5'd0, "R11 op10 40 bits");
    send({2'b10, 1'b0, 32'hFFFF_0000, 5'd1}, 40, 0, 80);
    push(2, 2'd0, 2'b00, 1'b0, 32'h0, 5'd0, "R11 one bit");
    send(40'h1, 1, 0, 80);

    // R4: bit errors between and below the windows
    push(1, 2'd0, 2'b00, 1'b0, 32'h0, 5'd0, "R4 interval 40");
    highfor(50); lowfor(24); highfor(10); lowfor(40); highfor(10);
    chk(dl_active == 1'b0, "R4", "dl_active after bit error", dl_active, 0);
    lowfor(80);
    push(1, 2'd0, 2'b00, 1'b0, 32'h0, 5'd0, "R4 interval 10");
    highfor(50); lowfor(10); highfor(10); lowfor(80);

    // R2: short start gap, and start gap before init
    highfor(30); lowfor(3);
    chk(dl_active == 1'b0, "R2", "dl_active after short gap", dl_active, 0);
    lowfor(80);
    init_done = 1'b0;
    highfor(50); lowfor(3);
    chk(dl_active == 1'b0, "R2", "dl_active without init", dl_active, 0);
    lowfor(21); highfor(10); lowfor(80);
    init_done = 1'b1;

    // a normal frame still decodes afterwards (R6)
    push(0, 2'd0, 2'b11, 1'b0, 32'h0000_0001, 5'd31, "R6 after rejects");
    send({2'b11, 1'b0, 32'h0000_0001, 5'd31}, 40, 0, 80);

    ticks(4);
    @(negedge clk);
    chk(q.size() == 0, "R12", "scoreboard leftovers", q.size(), 0);
    finish_run();
  end

endmodule